// File: doc/BRIEF.md
# Parallel Flash Programming-Mode Controller

This block is the target-side logic that lets an external programmer load and inspect a small on-chip code flash through a handful of port pins. The programmer never presents an address: an internal counter is cleared by a rising edge on a programming-reset pin and moves forward by one on each rising edge of an address-step pin. Four mode-select pins choose the operation, and a low-going program strobe launches it.

Byte writes and lock-bit programming run for a fixed, parameterised number of clock cycles. Chip erase needs the strobe held low for a long, also parameterised, time and then sweeps the array to all ones. While an operation runs, a ready flag is low and the programmer may poll the byte being written. Verify reads are suppressed once either lock bit is set, and a signature mode returns two fixed identification bytes. All pins are asynchronous to the system clock and pass through synchronisers. The flash array is a behavioural memory with one write port and one clear port.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After system reset, ready_o is 1, data_oe_o is 0, data_o is 0, both lock bits are clear and the address counter is 0.
- R2: A rising edge on pgm_rst_i returns the address counter to 0 from any value.
- R3: Each rising edge on addr_step_i adds one to the address counter, and the counter wraps from 2^ADDR_W-1 to 0.
- R4: With mode_sel_i = 0111 and hv_det_i high, a rising edge on strobe_n_i drops ready_o within a few cycles. ready_o stays low for exactly PROG_CYC cycles, and the byte on data_i is then stored at the counter address.
- R5: While a byte write is in progress, mode_sel_i = 0011 at the written address gives data_o = {~bit7 of the written byte, 7'b0}. Once ready_o returns high, it gives the full written byte.
- R6: With mode_sel_i = 1000, a strobe held low for at least ERASE_CYC cycles and then released drops ready_o for exactly 2^ADDR_W cycles. It sets every byte to FFh and clears both lock bits. A shorter low pulse does nothing.
- R7: With mode_sel_i = 0000, data_o is 1Eh at address 0, 21h at address 1 and 00h at any other address.
- R8: A strobe in mode 1111 programs lock bit 1 and a strobe in mode 1100 programs lock bit 2, each busy for PROG_CYC cycles. While either lock bit is set, reads in mode 0011 return FFh whatever the array holds. No mode reads the lock bits back.
- R9: A strobe under any mode code other than 0111, 0011, 1111, 1100, 1000 and 0000 starts nothing, and ready_o stays high.
- R10: Address-step edges and strobe edges that arrive while ready_o is low are ignored. The counter and the stored data are the same as if those edges had not come.
- R11: With hv_det_i low, a strobe starts no operation.
- R12: data_oe_o is 1 only in modes 0011 and 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| hv_det_i | input | 1 | High-voltage-present indication, enables strobed operations |
| pgm_rst_i | input | 1 | Programming reset pin; its rising edge clears the address counter |
| addr_step_i | input | 1 | Address-step pin; its rising edge advances the counter |
| strobe_n_i | input | 1 | Active-low program strobe; its rising edge starts an operation |
| mode_sel_i | input | 4 | Operation select code |
| data_i | input | DATA_W | Byte to be written |
| data_o | output | DATA_W | Read, polling or signature data |
| data_oe_o | output | 1 | Output-enable for data_o |
| ready_o | output | 1 | 1 when idle, 0 while an operation runs |

## Verification
Two things can fall in the same cycle here: an external edge (address step or a second strobe) and a running self-timed operation. The bench fires a step pulse, a new data byte and a full strobe pulse in the middle of a byte write's busy window. It then judges the result only at the ports. ready_o must not drop again after the write ends, and a read at the unchanged address must return the first byte, not an erased FFh from the next address. A second overlap is polling: the bench switches to read mode while the write timer runs and checks the complemented bit 7, then checks the full byte once ready_o rises.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   typedef enum logic [3:0] {
      M_SIG   = 4'b0000,
      M_READ  = 4'b0011,
      M_WRITE = 4'b0111,
      M_ERASE = 4'b1000,
      M_LB2   = 4'b1100,
      M_LB1   = 4'b1111
   } fpc_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PROG  = 2'd1,
      ST_ERASE = 2'd2
   } fpc_state_e;

   typedef enum logic [1:0] {
      OP_BYTE  = 2'd0,
      OP_LOCK1 = 2'd1,
      OP_LOCK2 = 2'd2
   } fpc_op_e;

   localparam logic [7:0] SIG_BYTE0 = 8'h1E;
   localparam logic [7:0] SIG_BYTE1 = 8'h21;

endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("fpc_sync: STAGES must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("fpc_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/fpc_addr_ctr.sv
module fpc_addr_ctr #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_lvl_i,
   input  logic          adv_lvl_i,
   input  logic          busy_i,
   output logic [AW-1:0] addr_o
);

   logic          clr_prev_q, adv_prev_q;
   logic          clr_rise, adv_rise;
   logic [AW-1:0] cnt_q;

   assign clr_rise = clr_lvl_i & ~clr_prev_q;
   assign adv_rise = adv_lvl_i & ~adv_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_prev_q <= 1'b0;
         adv_prev_q <= 1'b0;
         cnt_q      <= '0;
      end else begin
         clr_prev_q <= clr_lvl_i;
         adv_prev_q <= adv_lvl_i;
         if (clr_rise)
            cnt_q <= '0;
         else if (adv_rise && !busy_i)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign addr_o = cnt_q;

   // R10: the counter does not move while an operation is running
   assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !clr_rise) |=> (addr_o == $past(addr_o)));

endmodule

// File: rtl/fpc_array.sv
module fpc_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          ee_i,
   input  logic [AW-1:0] eaddr_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i)
         mem_q[waddr_i] <= wdata_i;
      else if (ee_i)
         mem_q[eaddr_i] <= '1;
   end

   assign rdata_o = mem_q[raddr_i];

   // R4: a committed write lands in the array
   assert_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

   // R6: a swept location reads as all ones afterwards
   assert_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_i && !we_i) |=> (mem_q[$past(eaddr_i)] == '1));

   // the sequencer never drives both ports together
   assert_ports_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(we_i && ee_i));

endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
   import fpc_pkg::*;
#(
   parameter int AW        = 11,
   parameter int DW        = 8,
   parameter int PROG_CYC  = 120000,
   parameter int ERASE_CYC = 1000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe_n_i,
   input  logic          hv_i,
   input  logic [3:0]    mode_i,
   input  logic [DW-1:0] data_i,
   input  logic [AW-1:0] addr_i,
   output logic          busy_o,
   output logic          we_o,
   output logic [AW-1:0] waddr_o,
   output logic [DW-1:0] wdata_o,
   output logic          ee_o,
   output logic [AW-1:0] eaddr_o,
   output logic [1:0]    lock_o,
   output logic          poll_o
);

   localparam int DEPTH = 1 << AW;
   localparam int TMAX  = (PROG_CYC > DEPTH) ? PROG_CYC : DEPTH;
   localparam int TW    = $clog2(TMAX + 1);
   localparam int LW    = $clog2(ERASE_CYC + 1);
   localparam logic [TW-1:0] T_PROG_LAST  = TW'(PROG_CYC - 1);
   localparam logic [TW-1:0] T_ERASE_LAST = TW'(DEPTH - 1);
   localparam logic [LW-1:0] L_MAX        = LW'(ERASE_CYC);

   fpc_state_e    st_q;
   fpc_op_e       op_q;
   logic [TW-1:0] tmr_q;
   logic [LW-1:0] low_q;
   logic          prev_q;
   logic [AW-1:0] tgt_addr_q;
   logic [DW-1:0] tgt_data_q;
   logic [1:0]    lock_q;
   logic          rise;

   assign rise = strobe_n_i & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         op_q       <= OP_BYTE;
         tmr_q      <= '0;
         low_q      <= '0;
         prev_q     <= 1'b1;
         tgt_addr_q <= '0;
         tgt_data_q <= '0;
         lock_q     <= 2'b00;
      end else begin
         prev_q <= strobe_n_i;
         if (strobe_n_i)
            low_q <= '0;
         else if (low_q != L_MAX)
            low_q <= low_q + 1'b1;

         case (st_q)
            ST_IDLE: begin
               if (rise && hv_i) begin
                  case (mode_i)
                     M_WRITE: begin
                        st_q       <= ST_PROG;
                        op_q       <= OP_BYTE;
                        tmr_q      <= T_PROG_LAST;
                        tgt_addr_q <= addr_i;
                        tgt_data_q <= data_i;
                     end
                     M_LB1: begin
                        st_q  <= ST_PROG;
                        op_q  <= OP_LOCK1;
                        tmr_q <= T_PROG_LAST;
                     end
                     M_LB2: begin
                        st_q  <= ST_PROG;
                        op_q  <= OP_LOCK2;
                        tmr_q <= T_PROG_LAST;
                     end
                     M_ERASE: begin
                        if (low_q == L_MAX) begin
                           st_q  <= ST_ERASE;
                           tmr_q <= '0;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            ST_PROG: begin
               if (tmr_q == '0) begin
                  st_q <= ST_IDLE;
                  if (op_q == OP_LOCK1) lock_q[0] <= 1'b1;
                  if (op_q == OP_LOCK2) lock_q[1] <= 1'b1;
               end else begin
                  tmr_q <= tmr_q - 1'b1;
               end
            end
            ST_ERASE: begin
               if (tmr_q == T_ERASE_LAST) begin
                  st_q   <= ST_IDLE;
                  lock_q <= 2'b00;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (st_q != ST_IDLE);
   assign we_o    = (st_q == ST_PROG) && (op_q == OP_BYTE) && (tmr_q == '0);
   assign waddr_o = tgt_addr_q;
   assign wdata_o = tgt_data_q;
   assign ee_o    = (st_q == ST_ERASE);
   assign eaddr_o = tmr_q[AW-1:0];
   assign lock_o  = lock_q;
   assign poll_o  = (st_q == ST_PROG) && (op_q == OP_BYTE);

   // R4: an accepted write strobe makes the block busy on the next cycle
   assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && hv_i && rise && mode_i == M_WRITE) |=> busy_o);

   // R10: strobes while busy do not retarget the running write
   assert_ign_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && rise) |=> ($stable(waddr_o) && $stable(wdata_o)));

   // R11: without high voltage an idle sequencer stays idle
   assert_no_hv_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!hv_i && !busy_o) |=> !busy_o);

   // R6: leaving an erase leaves both lock bits clear
   assert_lock_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ee_o) && !ee_o) |-> (lock_o == 2'b00));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import fpc_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 8,
   parameter int PROG_CYC    = 120000,
   parameter int ERASE_CYC   = 1000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hv_det_i,
   input  logic              pgm_rst_i,
   input  logic              addr_step_i,
   input  logic              strobe_n_i,
   input  logic [3:0]        mode_sel_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_o,
   output logic              ready_o
);

   localparam int SW = DATA_W + 8;
   localparam logic [SW-1:0] SYNC_RST = SW'(1) << (DATA_W + 4);

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("flash_prog_ctrl: DATA_W must be 8");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("flash_prog_ctrl: ADDR_W must be at least 2");
      end
      if (PROG_CYC < 1) begin : g_bad_prog
         $error("flash_prog_ctrl: PROG_CYC must be at least 1");
      end
      if (ERASE_CYC < 1) begin : g_bad_erase
         $error("flash_prog_ctrl: ERASE_CYC must be at least 1");
      end
   endgenerate

   logic [SW-1:0]     pins_s;
   logic              s_hv, s_clr, s_step, s_strobe_n;
   logic [3:0]        s_mode;
   logic [DATA_W-1:0] s_data;

   fpc_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({hv_det_i, pgm_rst_i, addr_step_i, strobe_n_i, mode_sel_i, data_i}),
      .q_o   (pins_s)
   );

   assign {s_hv, s_clr, s_step, s_strobe_n, s_mode, s_data} = pins_s;

   logic              busy;
   logic [ADDR_W-1:0] addr;
   logic              we, ee, poll;
   logic [ADDR_W-1:0] waddr, eaddr;
   logic [DATA_W-1:0] wdata, rdata;
   logic [1:0]        lock;

   fpc_addr_ctr #(.AW(ADDR_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_lvl_i (s_clr),
      .adv_lvl_i (s_step),
      .busy_i    (busy),
      .addr_o    (addr)
   );

   fpc_seq #(.AW(ADDR_W), .DW(DATA_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_n_i (s_strobe_n),
      .hv_i       (s_hv),
      .mode_i     (s_mode),
      .data_i     (s_data),
      .addr_i     (addr),
      .busy_o     (busy),
      .we_o       (we),
      .waddr_o    (waddr),
      .wdata_o    (wdata),
      .ee_o       (ee),
      .eaddr_o    (eaddr),
      .lock_o     (lock),
      .poll_o     (poll)
   );

   fpc_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .ee_i    (ee),
      .eaddr_i (eaddr),
      .raddr_i (addr),
      .rdata_o (rdata)
   );

   logic [DATA_W-1:0] rd_nxt;
   logic              oe_nxt;

   always_comb begin
      rd_nxt = '0;
      oe_nxt = 1'b0;
      case (s_mode)
         M_READ: begin
            oe_nxt = 1'b1;
            if (poll && addr == waddr)
               rd_nxt = {~wdata[DATA_W-1], {(DATA_W-1){1'b0}}};
            else if (|lock)
               rd_nxt = '1;
            else
               rd_nxt = rdata;
         end
         M_SIG: begin
            oe_nxt = 1'b1;
            if (addr == ADDR_W'(0))
               rd_nxt = SIG_BYTE0;
            else if (addr == ADDR_W'(1))
               rd_nxt = SIG_BYTE1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o    <= '0;
         data_oe_o <= 1'b0;
      end else begin
         data_o    <= rd_nxt;
         data_oe_o <= oe_nxt;
      end
   end

   assign ready_o = ~busy;

   // R12: the output enable follows the synchronised mode one cycle later
   assert_oe_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> ($past(s_mode) == M_READ || $past(s_mode) == M_SIG));

endmodule

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;

   localparam int AW    = 11;
   localparam int DEPTH = 1 << AW;
   localparam int PC    = 60;
   localparam int EC    = 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hv = 1'b0;
   logic       prst = 1'b0;
   logic       step = 1'b0;
   logic       strb_n = 1'b1;
   logic [3:0] mode = 4'b0101;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       oe, rdy;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [7:0] exp_mem [DEPTH];

   always #2 clk = ~clk;

   flash_prog_ctrl #(.ADDR_W(AW), .DATA_W(8), .PROG_CYC(PC), .ERASE_CYC(EC), .SYNC_STAGES(2)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .hv_det_i    (hv),
      .pgm_rst_i   (prst),
      .addr_step_i (step),
      .strobe_n_i  (strb_n),
      .mode_sel_i  (mode),
      .data_i      (din),
      .data_o      (dout),
      .data_oe_o   (oe),
      .ready_o     (rdy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_step();
      step = 1'b1; wait_n(3);
      step = 1'b0; wait_n(3);
   endtask

   task automatic do_clr();
      prst = 1'b0; wait_n(3);
      prst = 1'b1; wait_n(3);
   endtask

   task automatic rd(input logic [3:0] m, output logic [7:0] d);
      mode = m; wait_n(6);
      d = dout;
   endtask

   // strobe an operation and count the cycles ready stays low;
   // poll_en samples data_o mid-write in read mode; disturb fires step and
   // strobe edges while busy
   task automatic strobe_op(input logic [3:0] m, input logic [7:0] d, input int low,
                            input bit poll_en, input bit disturb,
                            output int cyc, output logic [7:0] pv);
      int w = 0;
      cyc = 0;
      pv = 8'hxx;
      mode = m; din = d;
      wait_n(3);
      strb_n = 1'b0; wait_n(low);
      strb_n = 1'b1;
      while (rdy && w < 10) begin @(negedge clk); w++; end
      while (!rdy && cyc < 5000) begin
         cyc++;
         if (poll_en && cyc == 6) mode = 4'b0011;
         if (poll_en && cyc == 16) pv = dout;
         if (disturb) begin
            if (cyc == 5) step = 1'b1;
            if (cyc == 10) step = 1'b0;
            if (cyc == 12) din = ~d;
            if (cyc == 15) strb_n = 1'b0;
            if (cyc == 20) strb_n = 1'b1;
         end
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int c;
      int bad;
      logic [7:0] v, pv, d;
      void'($urandom(32'h5EED_0042));
      wait_n(4);
      rst_n = 1'b1;
      wait_n(4);

      // R1: reset state
      chk("R1 ready", rdy, 1);
      chk("R1 oe", oe, 0);
      chk("R1 data", dout, 0);
      hv = 1'b1;
      do_clr();

      // R6: full erase, exact busy length, then sweep-read all bytes
      strobe_op(4'b1000, 8'h00, EC + 10, 0, 0, c, pv);
      chk("R6 erase busy cycles", c, DEPTH);
      bad = 0;
      mode = 4'b0011;
      for (int i = 0; i < DEPTH; i++) begin
         wait_n(5);
         if (dout !== 8'hFF) bad++;
         exp_mem[i] = 8'hFF;
         do_step();
      end
      chk("R6 bytes not FF", bad, 0);

      // R3: counter wrapped to 0, write A5 there
      strobe_op(4'b0111, 8'hA5, 3, 0, 0, c, pv);
      chk("R4 write busy cycles", c, PC);
      exp_mem[0] = 8'hA5;
      do_clr();
      rd(4'b0011, v);
      chk("R3 wrap to address 0", v, 8'hA5);
      chk("R12 oe in read", oe, 1);

      // R2: clear from a non-zero address
      do_step(); do_step(); do_step();
      do_clr();
      rd(4'b0011, v);
      chk("R2 clear on rising reset pin", v, 8'hA5);

      // R4 R5: random writes at addresses 1..12, some polled
      do_step();
      for (int i = 1; i <= 12; i++) begin
         d = 8'($urandom_range(0, 255));
         if (i == 2) d = 8'h80;
         if (i == 3) d = 8'h7F;
         strobe_op(4'b0111, d, 3, (i % 3) != 0, 0, c, pv);
         exp_mem[i] = d;
         if ((i % 3) != 0) begin
            chk("R5 polling bit7 complement", pv, {~d[7], 7'b0});
            rd(4'b0011, v);
            chk("R5 full byte after write", v, d);
         end
         do_step();
      end
      do_clr();
      do_step();
      for (int i = 1; i <= 12; i++) begin
         rd(4'b0011, v);
         chk("R3 R4 readback", v, exp_mem[i]);
         do_step();
      end

      // R7: signature bytes
      do_clr();
      rd(4'b0000, v);
      chk("R7 signature 0", v, 8'h1E);
      chk("R12 oe in signature", oe, 1);
      do_step();
      rd(4'b0000, v);
      chk("R7 signature 1", v, 8'h21);
      do_step();
      rd(4'b0000, v);
      chk("R7 signature other", v, 8'h00);

      // R9: undefined mode code starts nothing
      strobe_op(4'b0101, 8'h33, 3, 0, 0, c, pv);
      chk("R9 undefined mode busy", c, 0);
      chk("R12 oe in undefined mode", oe, 0);
      mode = 4'b0111; wait_n(6);
      chk("R12 oe in write mode", oe, 0);

      // R11: no high voltage, no write at address 2
      hv = 1'b0;
      strobe_op(4'b0111, 8'h00, 3, 0, 0, c, pv);
      chk("R11 strobe without hv", c, 0);
      hv = 1'b1;
      rd(4'b0011, v);
      chk("R11 byte unchanged", v, exp_mem[2]);

      // R10: disturbances during a write to address 20
      do_clr();
      for (int i = 0; i < 20; i++) do_step();
      strobe_op(4'b0111, 8'h3C, 3, 0, 1, c, pv);
      chk("R10 busy length with disturb", c, PC);
      wait_n(20);
      chk("R10 no second write", rdy, 1);
      rd(4'b0011, v);
      chk("R10 address and data kept", v, 8'h3C);
      exp_mem[20] = 8'h3C;

      // R6: short erase pulse ignored
      strobe_op(4'b1000, 8'h00, 20, 0, 0, c, pv);
      chk("R6 short erase ignored", c, 0);
      rd(4'b0011, v);
      chk("R6 data after short erase", v, 8'h3C);

      // R8: lock bit 1 hides verify data
      strobe_op(4'b1111, 8'h00, 3, 0, 0, c, pv);
      chk("R8 lock1 busy cycles", c, PC);
      rd(4'b0011, v);
      chk("R8 read with lock1", v, 8'hFF);

      // R6: erase clears locks
      strobe_op(4'b1000, 8'h00, EC + 5, 0, 0, c, pv);
      chk("R6 erase after lock", c, DEPTH);
      strobe_op(4'b0111, 8'h12, 3, 0, 0, c, pv);
      rd(4'b0011, v);
      chk("R6 locks cleared by erase", v, 8'h12);

      // R8: lock bit 2
      strobe_op(4'b1100, 8'h00, 3, 0, 0, c, pv);
      chk("R8 lock2 busy cycles", c, PC);
      rd(4'b0011, v);
      chk("R8 read with lock2", v, 8'hFF);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule